// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This block executes the memory instructions of a small 16-bit processor. For a load or a store it adds a base register and an index register to form the effective address. It can also update the index register, either after the access (post-increment) or before the address is formed (pre-decrement). The step is the access size: 1 for a byte and 2 for a word. It drives a simple synchronous memory port and writes loaded data back into a register file of its own. It also executes an immediate byte load, which replaces only the low byte of a register.

The unit takes one command at a time through a valid/ready pair. A store or an immediate load finishes in the cycle it is accepted. A load issues its read in the accepted cycle, takes the registered read data one cycle later and writes it back then. A `done` pulse marks the first cycle in which every register update of a command can be seen.

Top module: `idx_ldst_unit`

## Requirements
- R1: The effective address on `mem_addr` is base register (`cmd_rb`) plus index register (`cmd_ri`). In plain mode (`cmd_mode` = 0, and the unused code 3) neither register is changed.
- R2: In post-increment mode (`cmd_mode` = 1) the access uses base plus the unmodified index, and the index register then holds index plus the step.
- R3: In pre-decrement mode (`cmd_mode` = 2) the index register is reduced by the step first, and base plus the reduced index is the access address.
- R4: The step is 1 when `cmd_word` = 0 (byte) and 2 when `cmd_word` = 1 (word).
- R5: All three index modes apply to loads (`cmd_op` = 0) and stores (`cmd_op` = 1). A store drives `mem_we` with register `cmd_rd` on `mem_wdata` for a word, or with its low byte and a zero upper byte for a byte. The data is the register value before any index update in the same command.
- R6: An immediate load (`cmd_op` = 2) writes `cmd_imm` into the low byte of register `cmd_rd` and keeps its upper byte. `cmd_op` = 3 does nothing.
- R7: There are eight 16-bit registers, and all reset to zero. Register 0 always reads zero, and every write to it is dropped.
- R8: A byte load takes `mem_rdata[7:0]` and zero-extends it. A word load takes all of `mem_rdata`, with the byte at the effective address on bits 15:8 (big-endian).
- R9: When a load's destination is also its index register, the loaded data is what the register holds afterwards.
- R10: A store or immediate load raises `done` in the cycle after acceptance. A load raises `mem_re` in the accepted cycle, holds `cmd_ready` low for one cycle, and raises `done` two cycles after acceptance. A command offered while `cmd_ready` is low is ignored.
- R11: Address and index arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 2 | 0 load, 1 store, 2 immediate byte load, 3 no-op |
| cmd_word | input | 1 | 1 word access, 0 byte access |
| cmd_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement |
| cmd_rd | input | 3 | Destination (load/immediate) or source (store) register |
| cmd_rb | input | 3 | Base register |
| cmd_ri | input | 3 | Index register |
| cmd_imm | input | 8 | Immediate byte |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_word | output | 1 | Access size, 1 word |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| done | output | 1 | Command write-backs visible |

## Verification
The bench checks that post-increment puts the old index on the bus and pre-decrement puts the new one. A design with the two swapped would be off by one step in the address and would still leave the same index value. Byte and word steps are mixed within one index walk, so a fixed step of one or two shows up as a wrong address on the next access. The bench also covers these cases:
- A load whose destination equals its index. A design that lets the index update win would return the index plus the step instead of the memory data.
- Read data whose upper byte is not zero, so a byte load that fails to zero-extend is exposed.
- Register 0 used as a target and as a decremented index.
- Wrap-around at the top of the address space.
- A store offered during a load's busy cycle. A design that took this command would write memory.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_IMM   = 2'd2,
      OP_NONE  = 2'd3
   } ldst_op_e;

   typedef enum logic [1:0] {
      IX_PLAIN   = 2'd0,
      IX_POSTINC = 2'd1,
      IX_PREDEC  = 2'd2,
      IX_SPARE   = 2'd3
   } ix_mode_e;

endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
   parameter int DATA_W    = 16,
   parameter int REG_COUNT = 8,
   parameter int REG_AW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] rd_a_sel,
   output logic [DATA_W-1:0] rd_a_val,
   input  logic [REG_AW-1:0] rd_b_sel,
   output logic [DATA_W-1:0] rd_b_val,
   input  logic [REG_AW-1:0] rd_c_sel,
   output logic [DATA_W-1:0] rd_c_val,
   input  logic              wr_pri_en,
   input  logic [REG_AW-1:0] wr_pri_sel,
   input  logic [DATA_W-1:0] wr_pri_val,
   input  logic              wr_sec_en,
   input  logic [REG_AW-1:0] wr_sec_sel,
   input  logic [DATA_W-1:0] wr_sec_val
);

   logic [DATA_W-1:0] regs [REG_COUNT];

   generate
      if (REG_COUNT < 2) begin : g_bad_count
         $error("ldst_regfile: REG_COUNT must be at least 2");
      end
      if (REG_AW != $clog2(REG_COUNT)) begin : g_bad_aw
         $error("ldst_regfile: REG_AW must equal clog2(REG_COUNT)");
      end
   endgenerate

   generate
      for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign regs[g] = '0;
         end else begin : g_store
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  regs[g] <= '0;
               end else if (wr_pri_en && wr_pri_sel == REG_AW'(g)) begin
                  regs[g] <= wr_pri_val;
               end else if (wr_sec_en && wr_sec_sel == REG_AW'(g)) begin
                  regs[g] <= wr_sec_val;
               end
            end
         end
      end
   endgenerate

   assign rd_a_val = regs[rd_a_sel];
   assign rd_b_val = regs[rd_b_sel];
   assign rd_c_val = regs[rd_c_sel];

   // R9: same-register collision resolves to the primary (data) port
   assert_data_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pri_en && wr_sec_en && wr_pri_sel == wr_sec_sel && wr_pri_sel != '0)
      |=> regs[$past(wr_pri_sel)] == $past(wr_pri_val));

   // R2: a lone index write lands in the addressed register
   assert_index_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sec_en && wr_sec_sel != '0 && !(wr_pri_en && wr_pri_sel == wr_sec_sel))
      |=> regs[$past(wr_sec_sel)] == $past(wr_sec_val));

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu #(
   parameter int AW = 16
) (
   input  logic [AW-1:0]       base,
   input  logic [AW-1:0]       index,
   input  logic                is_word,
   input  ldst_pkg::ix_mode_e  mode,
   output logic [AW-1:0]       ea,
   output logic [AW-1:0]       idx_next,
   output logic                idx_upd
);
   import ldst_pkg::*;

   localparam logic [AW-1:0] STEP_BYTE = AW'(1);
   localparam logic [AW-1:0] STEP_WORD = AW'(2);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("ldst_agu: AW must be at least 2");
      end
   endgenerate

   logic [AW-1:0] step;
   assign step = is_word ? STEP_WORD : STEP_BYTE;

   always_comb begin
      unique case (mode)
         IX_POSTINC: begin
            ea       = base + index;
            idx_next = index + step;
            idx_upd  = 1'b1;
         end
         IX_PREDEC: begin
            idx_next = index - step;
            ea       = base + idx_next;
            idx_upd  = 1'b1;
         end
         default: begin
            ea       = base + index;
            idx_next = index;
            idx_upd  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ldst_lane.sv
module ldst_lane #(
   parameter int DATA_W = 16
) (
   input  logic                  is_word,
   input  logic [DATA_W-1:0]     st_src,
   output logic [DATA_W-1:0]     st_bus,
   input  logic [DATA_W-1:0]     ld_bus,
   output logic [DATA_W-1:0]     ld_val,
   input  logic [DATA_W-1:0]     imm_old,
   input  logic [DATA_W/2-1:0]   imm_byte,
   output logic [DATA_W-1:0]     imm_val
);
   localparam int BYTE_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_w
         $error("ldst_lane: DATA_W must be even");
      end
   endgenerate

   assign st_bus  = is_word ? st_src : {{BYTE_W{1'b0}}, st_src[BYTE_W-1:0]};
   assign ld_val  = is_word ? ld_bus : {{BYTE_W{1'b0}}, ld_bus[BYTE_W-1:0]};
   assign imm_val = {imm_old[DATA_W-1:BYTE_W], imm_byte};

endmodule

// File: rtl/idx_ldst_unit.sv
module idx_ldst_unit #(
   parameter int DATA_W    = 16,
   parameter int REG_COUNT = 8,
   parameter int REG_AW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [1:0]          cmd_op,
   input  logic                cmd_word,
   input  logic [1:0]          cmd_mode,
   input  logic [REG_AW-1:0]   cmd_rd,
   input  logic [REG_AW-1:0]   cmd_rb,
   input  logic [REG_AW-1:0]   cmd_ri,
   input  logic [DATA_W/2-1:0] cmd_imm,
   output logic [DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic                mem_we,
   output logic                mem_re,
   output logic                mem_word,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                done
);
   import ldst_pkg::*;

   localparam int BYTE_W = DATA_W / 2;

   generate
      if (DATA_W != 2 * BYTE_W) begin : g_bad_w
         $error("idx_ldst_unit: DATA_W must be two bytes wide");
      end
   endgenerate

   ldst_op_e  op;
   ix_mode_e  mode;
   assign op   = ldst_op_e'(cmd_op);
   assign mode = ix_mode_e'(cmd_mode);

   logic [DATA_W-1:0] q_base, q_index, q_data;
   logic [DATA_W-1:0] agu_ea, agu_idx_next;
   logic              agu_idx_upd;
   logic [DATA_W-1:0] st_bus, ld_val, imm_val;

   logic              pend_q;
   logic [REG_AW-1:0] pend_rd_q, pend_ri_q;
   logic              pend_word_q, pend_idx_en_q;
   logic [DATA_W-1:0] pend_idx_val_q;
   logic              done_q;

   logic              issue, issue_ld, issue_st, issue_imm;
   logic              wa_en, wb_en;
   logic [REG_AW-1:0] wa_sel, wb_sel;
   logic [DATA_W-1:0] wa_val, wb_val;

   assign cmd_ready = !pend_q;
   assign issue     = cmd_valid && cmd_ready;
   assign issue_ld  = issue && op == OP_LOAD;
   assign issue_st  = issue && op == OP_STORE;
   assign issue_imm = issue && op == OP_IMM;

   ldst_regfile #(
      .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .REG_AW(REG_AW)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_a_sel(cmd_rb), .rd_a_val(q_base),
      .rd_b_sel(cmd_ri), .rd_b_val(q_index),
      .rd_c_sel(cmd_rd), .rd_c_val(q_data),
      .wr_pri_en(wa_en), .wr_pri_sel(wa_sel), .wr_pri_val(wa_val),
      .wr_sec_en(wb_en), .wr_sec_sel(wb_sel), .wr_sec_val(wb_val)
   );

   ldst_agu #(.AW(DATA_W)) u_agu (
      .base(q_base), .index(q_index), .is_word(cmd_word), .mode(mode),
      .ea(agu_ea), .idx_next(agu_idx_next), .idx_upd(agu_idx_upd)
   );

   ldst_lane #(.DATA_W(DATA_W)) u_lane (
      .is_word(pend_q ? pend_word_q : cmd_word),
      .st_src(q_data), .st_bus(st_bus),
      .ld_bus(mem_rdata), .ld_val(ld_val),
      .imm_old(q_data), .imm_byte(cmd_imm), .imm_val(imm_val)
   );

   assign mem_addr  = agu_ea;
   assign mem_wdata = st_bus;
   assign mem_we    = issue_st;
   assign mem_re    = issue_ld;
   assign mem_word  = cmd_word;

   always_comb begin
      wa_en  = 1'b0;
      wa_sel = cmd_rd;
      wa_val = imm_val;
      wb_en  = 1'b0;
      wb_sel = cmd_ri;
      wb_val = agu_idx_next;
      if (pend_q) begin
         wa_en  = 1'b1;
         wa_sel = pend_rd_q;
         wa_val = ld_val;
         wb_en  = pend_idx_en_q;
         wb_sel = pend_ri_q;
         wb_val = pend_idx_val_q;
      end else begin
         wa_en = issue_imm;
         wb_en = issue_st && agu_idx_upd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q         <= 1'b0;
         pend_rd_q      <= '0;
         pend_ri_q      <= '0;
         pend_word_q    <= 1'b0;
         pend_idx_en_q  <= 1'b0;
         pend_idx_val_q <= '0;
         done_q         <= 1'b0;
      end else begin
         pend_q <= issue_ld;
         done_q <= issue_st || issue_imm || pend_q;
         if (issue_ld) begin
            pend_rd_q      <= cmd_rd;
            pend_ri_q      <= cmd_ri;
            pend_word_q    <= cmd_word;
            pend_idx_en_q  <= agu_idx_upd;
            pend_idx_val_q <= agu_idx_next;
         end
      end
   end

   assign done = done_q;

   // R10: single-cycle completion for stores and immediates
   assert_quick_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_st || issue_imm) |=> (done && cmd_ready));

   // R10: a load blocks one cycle and completes the cycle after
   assert_load_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (!cmd_ready && !done) ##1 done);

   // R10: nothing reaches memory while busy
   assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> (!mem_we && !mem_re));

   // R3: pre-decrement address uses the reduced index
   assert_predec_ea_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && mode == IX_PREDEC) |-> (mem_addr == q_base + agu_idx_next));

   // R1: plain mode never asks for an index write
   assert_plain_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (mode == IX_PLAIN || mode == IX_SPARE)) |-> !agu_idx_upd);

   // R6: immediate load preserves the upper byte
   assert_imm_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && !pend_q) |-> (wa_val[DATA_W-1:BYTE_W] == q_data[DATA_W-1:BYTE_W]));

endmodule

// File: tb/idx_ldst_unit_test.sv
module idx_ldst_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd3;
   logic        cmd_word = 1'b0;
   logic [1:0]  cmd_mode = 2'd0;
   logic [2:0]  cmd_rd = '0, cmd_rb = '0, cmd_ri = '0;
   logic [7:0]  cmd_imm = '0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we, mem_re, mem_word, done;

   logic [7:0]  mem [0:65535];
   int          tests = 0;
   int          fails = 0;
   logic [15:0] cap_addr, cap_wdata;
   logic        cap_we;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_ldst_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_mode(cmd_mode),
      .cmd_rd(cmd_rd), .cmd_rb(cmd_rb), .cmd_ri(cmd_ri), .cmd_imm(cmd_imm),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_word(mem_word), .mem_rdata(mem_rdata), .done(done)
   );

   // memory model: big-endian words, byte reads carry a non-zero filler on top
   always @(posedge clk) begin
      if (mem_re)
         mem_rdata <= mem_word ? {mem[mem_addr], mem[16'(mem_addr + 16'd1)]}
                               : {8'hA5, mem[mem_addr]};
      if (mem_we) begin
         if (mem_word) begin
            mem[mem_addr] = mem_wdata[15:8];
            mem[16'(mem_addr + 16'd1)] = mem_wdata[7:0];
         end else begin
            mem[mem_addr] = mem_wdata[7:0];
         end
      end
   end

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(logic [1:0] op, logic word, logic [1:0] mode,
                        logic [2:0] rd, logic [2:0] rb, logic [2:0] ri, logic [7:0] imm);
      int lat;
      @(negedge clk);
      cmd_op = op; cmd_word = word; cmd_mode = mode;
      cmd_rd = rd; cmd_rb = rb; cmd_ri = ri; cmd_imm = imm; cmd_valid = 1'b1;
      #1;
      cap_addr = mem_addr; cap_wdata = mem_wdata; cap_we = mem_we;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!done && lat < 5) begin
         @(posedge clk); @(negedge clk); lat++;
      end
      chk("R10 latency", 16'(lat), (op == 2'd0) ? 16'd2 : 16'd1);
   endtask

   task automatic peek(logic [2:0] r, output logic [15:0] v);
      issue(2'd1, 1'b1, 2'd0, r, 3'd0, 3'd0, 8'h00);
      v = cap_wdata;
   endtask

   task automatic setreg(logic [2:0] r, logic [15:0] v);
      mem[0] = v[15:8]; mem[1] = v[7:0];
      issue(2'd0, 1'b1, 2'd0, r, 3'd0, 3'd0, 8'h00);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R10 ready after reset", 16'(cmd_ready), 16'd1);
      chk("R10 done idle", 16'(done), 16'd0);
      chk("R5 no strobes", 16'({mem_we, mem_re}), 16'd0);
      peek(3'd5, v);
      chk("R7 reset value", v, 16'h0000);
   endtask

   task automatic t_imm_and_zero();
      logic [15:0] v;
      setreg(3'd1, 16'hAB12);
      issue(2'd2, 1'b0, 2'd1, 3'd1, 3'd0, 3'd0, 8'h34);
      peek(3'd1, v);
      chk("R6 imm low byte", v, 16'hAB34);
      issue(2'd2, 1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 8'h77);
      peek(3'd0, v);
      chk("R7 r0 imm ignored", v, 16'h0000);
      setreg(3'd0, 16'h5555);
      peek(3'd0, v);
      chk("R7 r0 load ignored", v, 16'h0000);
   endtask

   task automatic t_plain_load();
      logic [15:0] v;
      setreg(3'd2, 16'h1000);
      setreg(3'd3, 16'h0020);
      mem[16'h1020] = 8'hBE; mem[16'h1021] = 8'hEF;
      issue(2'd0, 1'b1, 2'd0, 3'd4, 3'd2, 3'd3, 8'h00);
      chk("R1 plain address", cap_addr, 16'h1020);
      peek(3'd4, v);
      chk("R8 word big-endian", v, 16'hBEEF);
      peek(3'd3, v);
      chk("R1 index kept", v, 16'h0020);
      setreg(3'd5, 16'hFFFF);
      issue(2'd0, 1'b0, 2'd3, 3'd5, 3'd2, 3'd3, 8'h00);
      peek(3'd5, v);
      chk("R8 byte zero-extend", v, 16'h00BE);
      peek(3'd3, v);
      chk("R1 spare mode keeps index", v, 16'h0020);
   endtask

   task automatic t_postinc_store();
      logic [15:0] v;
      setreg(3'd6, 16'h1234);
      issue(2'd1, 1'b0, 2'd1, 3'd6, 3'd2, 3'd3, 8'h00);
      chk("R2 byte addr", cap_addr, 16'h1020);
      chk("R5 byte wdata", cap_wdata, 16'h0034);
      chk("R5 byte stored", 16'(mem[16'h1020]), 16'h0034);
      peek(3'd3, v);
      chk("R4 byte step", v, 16'h0021);
      issue(2'd1, 1'b1, 2'd1, 3'd6, 3'd2, 3'd3, 8'h00);
      chk("R2 word addr", cap_addr, 16'h1021);
      chk("R5 word stored", {mem[16'h1021], mem[16'h1022]}, 16'h1234);
      peek(3'd3, v);
      chk("R4 word step", v, 16'h0023);
   endtask

   task automatic t_predec();
      logic [15:0] v;
      issue(2'd0, 1'b1, 2'd2, 3'd4, 3'd2, 3'd3, 8'h00);
      chk("R3 word addr", cap_addr, 16'h1021);
      peek(3'd4, v);
      chk("R3 word data", v, 16'h1234);
      peek(3'd3, v);
      chk("R3 word index", v, 16'h0021);
      setreg(3'd6, 16'h00C7);
      issue(2'd1, 1'b0, 2'd2, 3'd6, 3'd2, 3'd3, 8'h00);
      chk("R3 byte addr", cap_addr, 16'h1020);
      chk("R5 predec byte stored", 16'(mem[16'h1020]), 16'h00C7);
      peek(3'd3, v);
      chk("R3 byte index", v, 16'h0020);
      setreg(3'd3, 16'h0021);
      issue(2'd1, 1'b1, 2'd2, 3'd3, 3'd2, 3'd3, 8'h00);
      chk("R5 store data before update", cap_wdata, 16'h0021);
      setreg(3'd2, 16'h2000);
      issue(2'd0, 1'b1, 2'd2, 3'd4, 3'd2, 3'd0, 8'h00);
      chk("R7 r0 predec addr", cap_addr, 16'h1FFE);
      peek(3'd0, v);
      chk("R7 r0 index unchanged", v, 16'h0000);
   endtask

   task automatic t_collision();
      logic [15:0] v;
      setreg(3'd2, 16'h1000);
      setreg(3'd3, 16'h0020);
      mem[16'h1020] = 8'h34; mem[16'h1021] = 8'h12;
      issue(2'd0, 1'b1, 2'd1, 3'd3, 3'd2, 3'd3, 8'h00);
      peek(3'd3, v);
      chk("R9 load beats index", v, 16'h3412);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      setreg(3'd2, 16'hFFF0);
      setreg(3'd3, 16'h0012);
      setreg(3'd6, 16'hCAFE);
      issue(2'd1, 1'b1, 2'd1, 3'd6, 3'd2, 3'd3, 8'h00);
      chk("R11 wrapped addr", cap_addr, 16'h0002);
      chk("R11 wrapped store", {mem[2], mem[3]}, 16'hCAFE);
      setreg(3'd3, 16'h0001);
      issue(2'd0, 1'b1, 2'd2, 3'd4, 3'd2, 3'd3, 8'h00);
      chk("R11 predec addr wrap", cap_addr, 16'hFFEF);
      peek(3'd3, v);
      chk("R11 index wrap", v, 16'hFFFF);
   endtask

   task automatic t_busy();
      logic [15:0] v;
      setreg(3'd2, 16'h3000);
      setreg(3'd3, 16'h0000);
      setreg(3'd6, 16'h0099);
      mem[16'h3000] = 8'h11; mem[16'h3001] = 8'h22; mem[16'h3010] = 8'h5A;
      @(negedge clk);
      cmd_op = 2'd0; cmd_word = 1'b1; cmd_mode = 2'd0;
      cmd_rd = 3'd4; cmd_rb = 3'd2; cmd_ri = 3'd3; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10 busy ready low", 16'(cmd_ready), 16'd0);
      cmd_op = 2'd1; cmd_word = 1'b0; cmd_mode = 2'd1;
      cmd_rd = 3'd6; cmd_rb = 3'd2; cmd_ri = 3'd6;
      #1;
      chk("R10 busy no write", 16'(mem_we), 16'd0);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 load done", 16'(done), 16'd1);
      chk("R10 ignored store", 16'(mem[16'h3099]), 16'h0000);
      peek(3'd6, v);
      chk("R10 ignored index", v, 16'h0099);
      peek(3'd4, v);
      chk("R10 busy load data", v, 16'h1122);
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
      mem_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_imm_and_zero();
      t_plain_load();
      t_postinc_store();
      t_predec();
      t_collision();
      t_wrap();
      t_busy();
      report();
   end

endmodule